// File: doc/BRIEF.md
# Character LCD Instruction Decoder

This block sits behind the host bus of a character display controller and turns each host cycle into controller state changes and RAM accesses. A cycle is presented with `cmd_valid` together with two register-select bits, a read/write bit and an 8-bit data byte. The block keeps the address counter and the RAM space it points into, the entry mode, the display, cursor and blink switches, the five function-set bits, the arbitrator line selection and a wrap-around display window offset.

Every executed instruction raises `busy` for a time counted in ticks of the internal oscillator (`osc_tick`). Long instructions (clear and return-home) hold it for `T_LONG` ticks, all others for `T_SHORT` ticks. The busy/address read is the only cycle that takes effect while `busy` is high. RAM traffic leaves the block as single-cycle write and read strobes with a space select, an address and write data. Clearing the display runs a sweep that fills the display RAM with blanks and then zeroes the arbitrator RAM, and `busy` stays high until the sweep ends.

The second select bit opens an extended page (`rs_hi`=0, `rs_lo`=0, `rw`=0) that holds an arbitrator-line command and an arbitrator RAM address command.

Top module: `chr_lcd_cmd_core`

## Requirements
- R1: After reset, `busy`, `disp_on`, `cur_on`, `blink_on`, `shift_on`, `arb_line`, `func_cfg`, `addr_cnt`, `win_ofs` and both strobes are 0, and `inc_mode` is 1.
- R2: With `rs_hi`=1, `rs_lo`=0, `rw`=0 the highest set bit of `din` selects the command. 000001ab sets `inc_mode`=a and `shift_on`=b. 00001dcb sets `disp_on`=d, `cur_on`=c and `blink_on`=b. 001fffff copies the low five bits to `func_cfg`.
- R3: An executed clear (00000001) or home (0000001x) keeps `busy` high for `T_LONG` oscillator ticks. Every other executed command or data access keeps it high for `T_SHORT` ticks. A busy/address read does not raise `busy`.
- R4: While `busy` is high, every cycle except the busy/address read is ignored: no state changes and no strobe is issued.
- R5: A busy/address read (`rs_hi`=1, `rs_lo`=0, `rw`=1) puts {busy, address counter} on `dout` in the cycle after it.
- R6: 1aaaaaaa points the counter at display RAM address aaaaaaa. 01aaaaaa points it at character RAM address aaaaaa. On the extended page, 11aaaaaa points it at arbitrator RAM address aaaaaa masked to `AB_AW` bits. Space codes on `mem_sel` are 0 display, 1 character, 2 arbitrator.
- R7: A data write (`rs_hi`=1, `rs_lo`=1, `rw`=0) pulses `mem_wr` for one cycle, in the cycle after the command, with the current space, the counter value and `din`. The counter then moves by +1 (`inc_mode`=1) or -1, wrapping inside the space: 7 bits for display, 6 bits for character and `AB_AW` bits for arbitrator RAM.
- R8: A data read (`rw`=1, both selects 1) pulses `mem_rd` for one cycle with the space and counter value. `dout` takes `mem_rdata` one cycle later, and the counter moves as in R7.
- R9: When `shift_on` is 1, each data write changes `win_ofs` by +1 in increment mode and by -1 in decrement mode, wrapping in 7 bits. Data reads never change it.
- R10: 0001sr00 with s=0 moves the counter by +1 if r=1 or by -1 if r=0. With s=1 it changes `win_ofs` by -1 if r=1 or by +1 if r=0. Neither form strobes RAM.
- R11: Clear sets the counter and `win_ofs` to 0 and selects display RAM. It then writes 0x20 to display addresses 0 to `DD_SPAN`-1 in ascending order, one per cycle, and then writes 0x00 to every arbitrator address in ascending order.
- R12: Home sets the counter and `win_ofs` to 0, selects display RAM and issues no RAM strobe.
- R13: On the extended page, 0000001a sets `arb_line`=a. With `rs_hi`=0 and `rs_lo`=1, every cycle is ignored.
- R14: `mem_wr` and `mem_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle pulse per internal oscillator period |
| cmd_valid | input | 1 | Host cycle present this clock |
| rs_hi | input | 1 | First register-select bit |
| rs_lo | input | 1 | Second register-select bit |
| rw | input | 1 | 1 read, 0 write |
| din | input | 8 | Host data byte |
| dout | output | 8 | Host read data |
| busy | output | 1 | Execution in progress |
| mem_wr | output | 1 | RAM write strobe |
| mem_rd | output | 1 | RAM read strobe |
| mem_sel | output | 2 | RAM space: 0 display, 1 character, 2 arbitrator |
| mem_addr | output | 7 | RAM address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid while `mem_rd` is high |
| addr_cnt | output | 7 | Address counter |
| disp_on | output | 1 | Display enable |
| cur_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| inc_mode | output | 1 | Counter direction, 1 increment |
| shift_on | output | 1 | Window shift on data write |
| func_cfg | output | 5 | Function-set bits |
| arb_line | output | 1 | Arbitrator line selection |
| win_ofs | output | 7 | Display window offset |

## Verification
The assertions check on every cycle that the strobes never overlap and that a blocked cycle leaves the counter unchanged and issues no strobe. They also check that each executed command raises busy, that clear and home zero the counter and the window offset, that a data write carries the counter and data byte, and that the clear sweep advances one address per cycle inside its range. The bench scenarios are needed for what spans many cycles or depends on the command sequence: the tick-counted busy durations, the order of the clear sweep and its number of writes, wrapping in each RAM space, direction and shift interplay across a run of commands, and read data returning on `dout`.

// File: rtl/chr_lcd_pkg.sv
package chr_lcd_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_CLR, OP_HOME, OP_ENTRY, OP_DISP, OP_SHIFT, OP_FUNC,
    OP_CGADR, OP_DDADR, OP_STAT, OP_WR, OP_RD, OP_ALINE, OP_ABADR
  } op_e;

  typedef enum logic [1:0] {
    TGT_DD = 2'd0,
    TGT_CG = 2'd1,
    TGT_AB = 2'd2
  } tgt_e;

  localparam logic [7:0] BLANK_CODE = 8'h20;

  // counter step inside one RAM space
  function automatic logic [6:0] step_addr(input logic [6:0] a, input logic up,
                                           input logic [6:0] mask);
    logic [6:0] n;
    n = up ? a + 7'd1 : a - 7'd1;
    return n & mask;
  endfunction

  // window offset after one shift; content moving right lowers the offset
  function automatic logic [6:0] shift_ofs(input logic [6:0] o, input logic right);
    return right ? o - 7'd1 : o + 7'd1;
  endfunction

  function automatic logic is_long(input op_e op);
    return (op == OP_CLR) || (op == OP_HOME);
  endfunction

endpackage

// File: rtl/chr_lcd_decode.sv
module chr_lcd_decode
  import chr_lcd_pkg::*;
(
  input  logic       rs_hi,
  input  logic       rs_lo,
  input  logic       rw,
  input  logic [7:0] din,
  output op_e        op
);

  always_comb begin
    op = OP_NONE;
    if (rs_hi && rs_lo) begin
      op = rw ? OP_RD : OP_WR;
    end else if (rs_hi) begin
      if (rw) begin
        op = OP_STAT;
      end else begin
        casez (din)
          8'b1???????: op = OP_DDADR;
          8'b01??????: op = OP_CGADR;
          8'b001?????: op = OP_FUNC;
          8'b0001????: op = OP_SHIFT;
          8'b00001???: op = OP_DISP;
          8'b000001??: op = OP_ENTRY;
          8'b0000001?: op = OP_HOME;
          8'b00000001: op = OP_CLR;
          default:     op = OP_NONE;
        endcase
      end
    end else if (!rs_lo && !rw) begin
      casez (din)
        8'b11??????: op = OP_ABADR;
        8'b0000001?: op = OP_ALINE;
        default:     op = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/chr_lcd_busy_timer.sv
module chr_lcd_busy_timer #(
  parameter int T_LONG  = 410,
  parameter int T_SHORT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic start,
  input  logic long_sel,
  output logic busy
);

  localparam int CW = $clog2(T_LONG + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= long_sel ? CW'(T_LONG) : CW'(T_SHORT);
    end else if (osc_tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(T_LONG)); // R3
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R3
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !osc_tick && !start) |=> busy); // R3

endmodule

// File: rtl/chr_lcd_clr_sweep.sv
module chr_lcd_clr_sweep
  import chr_lcd_pkg::*;
#(
  parameter int DD_SPAN = 80,
  parameter int AB_AW   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       active,
  output logic       wr,
  output tgt_e       sel,
  output logic [6:0] addr,
  output logic [7:0] wdata
);

  localparam int AB_DEPTH = 1 << AB_AW;

  typedef enum logic [1:0] {SW_IDLE, SW_DD, SW_AB} sw_e;

  sw_e        st;
  logic [6:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SW_IDLE;
      idx <= '0;
    end else if (start) begin
      st  <= SW_DD;
      idx <= '0;
    end else begin
      case (st)
        SW_DD: begin
          if (idx == 7'(DD_SPAN - 1)) begin
            st  <= SW_AB;
            idx <= '0;
          end else begin
            idx <= idx + 7'd1;
          end
        end
        SW_AB: begin
          if (idx == 7'(AB_DEPTH - 1)) st <= SW_IDLE;
          else                         idx <= idx + 7'd1;
        end
        default: idx <= '0;
      endcase
    end
  end

  assign active = (st != SW_IDLE);
  assign wr     = active;
  assign sel    = (st == SW_AB) ? TGT_AB : TGT_DD;
  assign addr   = idx;
  assign wdata  = (st == SW_DD) ? BLANK_CODE : 8'h00;

  AST_SWEEP_DD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sel == TGT_DD) |-> (addr < 7'(DD_SPAN))); // R11
  AST_SWEEP_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start && $past(active) && sel == $past(sel)) |-> (addr == $past(addr) + 7'd1)); // R11

endmodule

// File: rtl/chr_lcd_cmd_core.sv
module chr_lcd_cmd_core
  import chr_lcd_pkg::*;
#(
  parameter int T_LONG  = 410,
  parameter int T_SHORT = 10,
  parameter int DD_SPAN = 80,
  parameter int AB_AW   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       cmd_valid,
  input  logic       rs_hi,
  input  logic       rs_lo,
  input  logic       rw,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       busy,
  output logic       mem_wr,
  output logic       mem_rd,
  output logic [1:0] mem_sel,
  output logic [6:0] mem_addr,
  output logic [7:0] mem_wdata,
  input  logic [7:0] mem_rdata,
  output logic [6:0] addr_cnt,
  output logic       disp_on,
  output logic       cur_on,
  output logic       blink_on,
  output logic       inc_mode,
  output logic       shift_on,
  output logic [4:0] func_cfg,
  output logic       arb_line,
  output logic [6:0] win_ofs
);

  localparam int         AB_DEPTH = 1 << AB_AW;
  localparam logic [6:0] AB_MASK  = 7'(AB_DEPTH - 1);

  op_e        op;
  tgt_e       tgt, sel_q, sw_sel;
  logic       tmr_busy, sw_active, sw_wr;
  logic [6:0] sw_addr, addr_q, cur_mask;
  logic [7:0] sw_wdata, wdata_q;
  logic       wr_q, rd_q;

  // named events for the assertions
  logic acc_ev, exec_ev, clr_ev;

  chr_lcd_decode u_dec (
    .rs_hi (rs_hi), .rs_lo (rs_lo), .rw (rw), .din (din), .op (op)
  );

  assign acc_ev  = cmd_valid && (op != OP_NONE) && ((op == OP_STAT) || !busy);
  assign exec_ev = acc_ev && (op != OP_STAT);
  assign clr_ev  = exec_ev && (op == OP_CLR);

  chr_lcd_busy_timer #(.T_LONG(T_LONG), .T_SHORT(T_SHORT)) u_tmr (
    .clk (clk), .rst_n (rst_n), .osc_tick (osc_tick),
    .start (exec_ev), .long_sel (is_long(op)), .busy (tmr_busy)
  );

  chr_lcd_clr_sweep #(.DD_SPAN(DD_SPAN), .AB_AW(AB_AW)) u_sweep (
    .clk (clk), .rst_n (rst_n), .start (clr_ev),
    .active (sw_active), .wr (sw_wr), .sel (sw_sel),
    .addr (sw_addr), .wdata (sw_wdata)
  );

  assign busy = tmr_busy || sw_active;

  always_comb begin
    case (tgt)
      TGT_CG:  cur_mask = 7'h3F;
      TGT_AB:  cur_mask = AB_MASK;
      default: cur_mask = 7'h7F;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_cnt <= '0;  tgt      <= TGT_DD;  win_ofs  <= '0;
      disp_on  <= 1'b0; cur_on  <= 1'b0;    blink_on <= 1'b0;
      inc_mode <= 1'b1; shift_on <= 1'b0;   func_cfg <= '0;
      arb_line <= 1'b0; dout    <= '0;
      wr_q     <= 1'b0; rd_q    <= 1'b0;    sel_q    <= TGT_DD;
      addr_q   <= '0;   wdata_q <= '0;
    end else begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      if (rd_q) dout <= mem_rdata;
      if (acc_ev) begin
        case (op)
          OP_STAT:  dout <= {busy, addr_cnt};
          OP_CLR, OP_HOME: begin
            addr_cnt <= '0;
            win_ofs  <= '0;
            tgt      <= TGT_DD;
          end
          OP_ENTRY: begin
            inc_mode <= din[1];
            shift_on <= din[0];
          end
          OP_DISP: begin
            disp_on  <= din[2];
            cur_on   <= din[1];
            blink_on <= din[0];
          end
          OP_SHIFT: begin
            if (din[3]) win_ofs  <= shift_ofs(win_ofs, din[2]);
            else        addr_cnt <= step_addr(addr_cnt, din[2], cur_mask);
          end
          OP_FUNC:  func_cfg <= din[4:0];
          OP_ALINE: arb_line <= din[0];
          OP_DDADR: begin
            addr_cnt <= din[6:0];
            tgt      <= TGT_DD;
          end
          OP_CGADR: begin
            addr_cnt <= {1'b0, din[5:0]};
            tgt      <= TGT_CG;
          end
          OP_ABADR: begin
            addr_cnt <= {1'b0, din[5:0]} & AB_MASK;
            tgt      <= TGT_AB;
          end
          OP_WR: begin
            wr_q     <= 1'b1;
            sel_q    <= tgt;
            addr_q   <= addr_cnt;
            wdata_q  <= din;
            addr_cnt <= step_addr(addr_cnt, inc_mode, cur_mask);
            if (shift_on) win_ofs <= shift_ofs(win_ofs, !inc_mode);
          end
          OP_RD: begin
            rd_q     <= 1'b1;
            sel_q    <= tgt;
            addr_q   <= addr_cnt;
            addr_cnt <= step_addr(addr_cnt, inc_mode, cur_mask);
          end
          default: ;
        endcase
      end
    end
  end

  assign mem_wr    = sw_wr || wr_q;
  assign mem_rd    = rd_q;
  assign mem_sel   = sw_active ? sw_sel   : sel_q;
  assign mem_addr  = sw_active ? sw_addr  : addr_q;
  assign mem_wdata = sw_active ? sw_wdata : wdata_q;

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd) && !(sw_wr && wr_q)); // R14
  AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy && op != OP_STAT) |=> ($stable(addr_cnt) && !wr_q && !rd_q)); // R4
  AST_HOME_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_ev && is_long(op)) |=> (addr_cnt == 7'd0 && win_ofs == 7'd0)); // R12
  AST_WRITE_CARRIES: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_ev && op == OP_WR) |=> (mem_wr && mem_addr == $past(addr_cnt) && mem_wdata == $past(din))); // R7
  AST_STATUS_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ev && op == OP_STAT && !busy) |=> !busy); // R5
  AST_EXEC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    exec_ev |=> busy); // R3

endmodule

// File: tb/test_chr_lcd_cmd_core.sv
`timescale 1ns/1ps
module test_chr_lcd_cmd_core;

  localparam int T_LONG  = 410;
  localparam int T_SHORT = 10;
  localparam int DD_SPAN = 80;
  localparam int AB_AW   = 4;
  localparam int AB_DEPTH = 1 << AB_AW;
  localparam int TICK_DIV = 4;

  logic       clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0;
  logic       cmd_valid = 1'b0, rs_hi = 1'b0, rs_lo = 1'b0, rw = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout, mem_wdata, mem_rdata;
  logic       busy, mem_wr, mem_rd, disp_on, cur_on, blink_on, inc_mode, shift_on, arb_line;
  logic [1:0] mem_sel;
  logic [6:0] mem_addr, addr_cnt, win_ofs;
  logic [4:0] func_cfg;

  int errs = 0, checks = 0;
  int wr_cnt = 0, rd_cnt = 0, overlap = 0;
  int dd_blank = 0, dd_order = 0, ab_zero = 0, ab_order = 0;
  logic [1:0] last_sel;
  logic [6:0] last_addr;
  logic [7:0] last_data;

  always #2.5 clk = ~clk;

  // external RAM model: read data is a fixed function of the address
  assign mem_rdata = {1'b0, mem_addr} ^ 8'h5A;

  chr_lcd_cmd_core #(.T_LONG(T_LONG), .T_SHORT(T_SHORT), .DD_SPAN(DD_SPAN), .AB_AW(AB_AW)) i_chr_lcd_cmd_core (
    .clk, .rst_n, .osc_tick, .cmd_valid, .rs_hi, .rs_lo, .rw, .din, .dout, .busy,
    .mem_wr, .mem_rd, .mem_sel, .mem_addr, .mem_wdata, .mem_rdata, .addr_cnt,
    .disp_on, .cur_on, .blink_on, .inc_mode, .shift_on, .func_cfg, .arb_line, .win_ofs
  );

  int div = 0;
  always @(negedge clk) begin
    div      <= (div == TICK_DIV - 1) ? 0 : div + 1;
    osc_tick <= (div == TICK_DIV - 1);
  end

  // strobe monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr && mem_rd) overlap++;
      if (mem_rd) rd_cnt++;
      if (mem_wr) begin
        wr_cnt++;
        last_sel = mem_sel; last_addr = mem_addr; last_data = mem_wdata;
        if (mem_sel == 2'd0 && mem_wdata == 8'h20) begin
          if (int'(mem_addr) != dd_blank) dd_order++;
          dd_blank++;
        end
        if (mem_sel == 2'd2 && mem_wdata == 8'h00) begin
          if (int'(mem_addr) != ab_zero) ab_order++;
          ab_zero++;
        end
      end
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] rs, input logic r, input logic [7:0] d);
    @(negedge clk);
    rs_hi = rs[1]; rs_lo = rs[0]; rw = r; din = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 6000) begin
      @(negedge clk);
      n++;
    end
    if (busy) chk(1'b0, "watchdog idle", 1, 0);
  endtask

  task automatic run_cmd(input logic [1:0] rs, input logic r, input logic [7:0] d);
    issue(rs, r, d);
    wait_idle();
  endtask

  // {rs[1:0], rw, din, exp ac, exp {disp,cur,blink,inc}, exp ofs}
  localparam int NV = 14;
  localparam logic [28:0] VEC [NV] = '{
    {2'b10, 1'b0, 8'h85, 7'd5,   4'b0001, 7'd0},
    {2'b10, 1'b0, 8'h0F, 7'd5,   4'b1111, 7'd0},
    {2'b10, 1'b0, 8'h14, 7'd6,   4'b1111, 7'd0},
    {2'b10, 1'b0, 8'h10, 7'd5,   4'b1111, 7'd0},
    {2'b10, 1'b0, 8'h1C, 7'd5,   4'b1111, 7'd127},
    {2'b10, 1'b0, 8'h18, 7'd5,   4'b1111, 7'd0},
    {2'b10, 1'b0, 8'h04, 7'd5,   4'b1110, 7'd0},
    {2'b11, 1'b0, 8'h41, 7'd4,   4'b1110, 7'd0},
    {2'b10, 1'b0, 8'h07, 7'd4,   4'b1111, 7'd0},
    {2'b11, 1'b0, 8'h42, 7'd5,   4'b1111, 7'd1},
    {2'b10, 1'b0, 8'h0A, 7'd5,   4'b0101, 7'd1},
    {2'b10, 1'b0, 8'h02, 7'd0,   4'b0101, 7'd0},
    {2'b10, 1'b0, 8'hFF, 7'd127, 4'b0101, 7'd0},
    {2'b11, 1'b0, 8'h43, 7'd0,   4'b0101, 7'd1}
  };

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog global", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n, w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!busy && !mem_wr && !mem_rd, "R1 busy/strobes", {busy, mem_wr, mem_rd}, 0);
    chk({disp_on, cur_on, blink_on, inc_mode, shift_on, arb_line} == 6'b000100, "R1 flags",
        {disp_on, cur_on, blink_on, inc_mode, shift_on, arb_line}, 6'b000100);
    chk(addr_cnt == 0 && win_ofs == 0 && func_cfg == 0, "R1 counters", {addr_cnt, win_ofs}, 0);

    // table walk: R2 R7 R9 R10 R12 sequence
    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      run_cmd(v[28:27], v[26], v[25:18]);
      chk(addr_cnt == v[17:11], $sformatf("R10/R7 vec%0d ac", i), addr_cnt, v[17:11]);
      chk({disp_on, cur_on, blink_on, inc_mode} == v[10:7], $sformatf("R2 vec%0d ctrl", i),
          {disp_on, cur_on, blink_on, inc_mode}, v[10:7]);
      chk(win_ofs == v[6:0], $sformatf("R9 vec%0d ofs", i), win_ofs, v[6:0]);
    end

    // R3 short busy length
    issue(2'b10, 1'b0, 8'h06);
    n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(n >= (T_SHORT - 1) * TICK_DIV && n <= (T_SHORT + 1) * TICK_DIV, "R3 short busy", n, T_SHORT * TICK_DIV);
    // R3 long busy length (home), R12 no strobe
    w0 = wr_cnt;
    issue(2'b10, 1'b0, 8'h03);
    n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(n >= (T_LONG - 1) * TICK_DIV && n <= (T_LONG + 1) * TICK_DIV, "R3 long busy", n, T_LONG * TICK_DIV);
    chk(wr_cnt == w0 && addr_cnt == 0, "R12 home no strobe", wr_cnt - w0, 0);

    // R5 status read idle, R3 no busy
    run_cmd(2'b10, 1'b0, 8'h93);
    issue(2'b10, 1'b1, 8'h00);
    chk(dout == 8'h13 && !busy, "R5 status idle", dout, 8'h13);

    // R4 ignored while busy; R5 status while busy
    issue(2'b10, 1'b0, 8'h0C);
    issue(2'b10, 1'b0, 8'hA0);
    issue(2'b11, 1'b0, 8'h55);
    issue(2'b10, 1'b1, 8'h00);
    chk(dout == 8'h93, "R5 status busy", dout, 8'h93);
    wait_idle();
    chk(addr_cnt == 7'h13, "R4 addr kept", addr_cnt, 7'h13);
    chk(disp_on == 1'b1 && cur_on == 1'b0, "R4 disp applied once", {disp_on, cur_on}, 2'b10);

    // R2 function set
    run_cmd(2'b10, 1'b0, 8'h35);
    chk(func_cfg == 5'h15, "R2 func", func_cfg, 5'h15);

    // R6 R7 character RAM, wrap in 6 bits
    run_cmd(2'b10, 1'b0, 8'h7F);
    chk(addr_cnt == 7'd63, "R6 cg addr", addr_cnt, 63);
    w0 = wr_cnt;
    run_cmd(2'b11, 1'b0, 8'h11);
    chk(wr_cnt == w0 + 1 && last_sel == 2'd1 && last_addr == 7'd63 && last_data == 8'h11,
        "R7 cg write", {last_sel, last_addr, last_data}, {2'd1, 7'd63, 8'h11});
    chk(addr_cnt == 7'd0, "R7 cg wrap", addr_cnt, 0);

    // R6 arbitrator RAM address on extended page, masked
    run_cmd(2'b00, 1'b0, 8'hF3);
    chk(addr_cnt == 7'h3 , "R6 ab addr", addr_cnt, 3);
    run_cmd(2'b11, 1'b0, 8'h66);
    chk(last_sel == 2'd2 && last_addr == 7'd3, "R6 ab write", {last_sel, last_addr}, {2'd2, 7'd3});

    // R8 read, R9 read leaves offset
    run_cmd(2'b10, 1'b0, 8'h8A);
    n = int'(win_ofs);
    w0 = rd_cnt;
    issue(2'b11, 1'b1, 8'h00);
    @(negedge clk);
    chk(rd_cnt == w0 + 1, "R8 rd strobe", rd_cnt - w0, 1);
    chk(dout == (8'h0A ^ 8'h5A), "R8 read data", dout, 8'h0A ^ 8'h5A);
    wait_idle();
    chk(addr_cnt == 7'd11, "R8 ac step", addr_cnt, 11);
    chk(int'(win_ofs) == n, "R9 read no shift", win_ofs, n);

    // R13 arbitrator line, select 01 ignored
    run_cmd(2'b00, 1'b0, 8'h03);
    chk(arb_line == 1'b1, "R13 line set", arb_line, 1);
    issue(2'b01, 1'b0, 8'h02);
    chk(!busy && arb_line == 1'b1, "R13 page01 ignored", {busy, arb_line}, 1);
    run_cmd(2'b00, 1'b0, 8'h02);
    chk(arb_line == 1'b0, "R13 line clr", arb_line, 0);

    // R11 clear sweep
    run_cmd(2'b10, 1'b0, 8'h1C);
    run_cmd(2'b10, 1'b0, 8'h45);
    dd_blank = 0; dd_order = 0; ab_zero = 0; ab_order = 0;
    run_cmd(2'b10, 1'b0, 8'h01);
    chk(dd_blank == DD_SPAN && dd_order == 0, "R11 blank sweep", dd_blank, DD_SPAN);
    chk(ab_zero == AB_DEPTH && ab_order == 0, "R11 arb sweep", ab_zero, AB_DEPTH);
    chk(addr_cnt == 0 && win_ofs == 0, "R11 ac/ofs", {addr_cnt, win_ofs}, 0);
    run_cmd(2'b11, 1'b0, 8'h77);
    chk(last_sel == 2'd0 && last_addr == 7'd0, "R11 target display", {last_sel, last_addr}, 0);

    chk(overlap == 0, "R14 strobe overlap", overlap, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule